// File: doc/BRIEF.md
# Synchronized Serial Debug Port

This block links an external debug host to the core debug logic over a slow serial connection. The host drives two asynchronous inputs: a serial clock and a serial data line. The port brings both into the core clock domain. It accepts a serial clock level only once that level has held for two core clock samples. On each accepted rising edge it shifts one host bit in and moves the response line on by one bit. Both directions carry a 17-bit frame, most significant bit first. The first bit is a status/control flag and the other 16 bits are a data word.

When a frame is complete, the port hands the received flag and word to the downstream command decoder with a one-cycle valid strobe. It then loads the next response frame from its response inputs, ready for the following exchange. A single command word is handled inside the port: the bus-recovery opcode. This opcode is not forwarded. Instead it produces a one-cycle force-acknowledge pulse, which the bus termination logic can combine into its transfer acknowledge to release a hung transfer.

Top module: `dbgSerialPort`

## Requirements
- R1: A change on `serClkIn` is accepted only after the new level has been sampled at the same value on two consecutive rising `clk` edges. A high pulse lasting a single `clk` period is ignored and does not disturb the frame in progress.
- R2: Each accepted rising edge of the serial clock shifts in one `serDataIn` bit, most significant bit first. After the 17th edge, `cmdValid` is high for exactly one `clk` cycle. At the same time, `cmdStatus` carries the first bit received and `cmdWord` carries the remaining 16 bits.
- R3: `serDataOut` is a registered output that changes only on the cycle after an accepted rising edge of the serial clock. It presents the current response frame most significant bit first: bit 16 is `respStatus` and bits 15..0 are `respWord`.
- R4: The response frame is captured from `respStatus`/`respWord` at the 17th accepted edge of each frame and is shifted out during the next frame. The first frame after reset sends all zeros.
- R5: A received frame whose 16-bit word equals 0x1C00, whatever its first bit, drives `forceAck` high for exactly one `clk` cycle and does not raise `cmdValid`.
- R6: Every other word, including those that differ from 0x1C00 in one bit, is passed on unchanged through `cmdValid`/`cmdWord`/`cmdStatus`, and `forceAck` stays low.
- R7: `cmdValid` and `forceAck` are never high in the same cycle.
- R8: A synchronous reset on `rst` clears the synchronizers, the bit counter and both shift registers. A partly received frame is discarded, and `serDataOut`, `cmdValid` and `forceAck` read 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| serClkIn | input | 1 | Asynchronous serial clock from the debug host |
| serDataIn | input | 1 | Asynchronous serial data from the debug host |
| respStatus | input | 1 | Status bit of the next response frame |
| respWord | input | 16 | Data word of the next response frame |
| serDataOut | output | 1 | Registered serial response to the host |
| cmdValid | output | 1 | One-cycle strobe: a forwarded command is present |
| cmdStatus | output | 1 | First bit of the last received frame |
| cmdWord | output | 16 | Data word of the last received frame |
| forceAck | output | 1 | One-cycle force transfer acknowledge toward the bus |

## Verification
The assertions rely on three assumptions about the inputs. The host keeps the serial clock at or below one fifth of the core rate. It does not move the data line near an accepted rising edge. Reset is held over the first clock edge. Under these assumptions, validated edges are several cycles apart, which makes the single-cycle strobe properties meaningful. The stimulus holds each serial clock half for four core cycles and changes the data line only at the start of a low half. The one deliberate violation is a single-cycle glitch, and it is shorter than the validation window.

// File: rtl/dbgPortPkg.sv
package dbgPortPkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic shiftEn;   // accepted rising serial edge
    logic frameEnd;  // accepted edge that completes a frame
  } portStrobe_t;
endpackage

// File: rtl/dbgPortCtrl.sv
module dbgPortCtrl
  import dbgPortPkg::*;
#(
  parameter int FRAME_BITS = 17
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        serClkIn,
  output portStrobe_t strobe
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  logic clkMeta, clkSync, clkPrev, clkLevel;
  logic [CNT_W-1:0] bitCnt;
  logic levelAgree, riseEvt;

  // a level counts once two consecutive samples agree
  assign levelAgree = (clkSync == clkPrev);
  assign riseEvt    = levelAgree && clkSync && !clkLevel;

  always_ff @(posedge clk) begin
    if (rst) begin
      clkMeta  <= 1'b0;
      clkSync  <= 1'b0;
      clkPrev  <= 1'b0;
      clkLevel <= 1'b0;
      bitCnt   <= '0;
    end else begin
      clkMeta <= serClkIn;
      clkSync <= clkMeta;
      clkPrev <= clkSync;
      if (levelAgree) clkLevel <= clkSync;
      if (riseEvt) bitCnt <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
    end
  end

  assign strobe.shiftEn  = riseEvt;
  assign strobe.frameEnd = riseEvt && (bitCnt == LAST_BIT);
endmodule

// File: rtl/dbgPortData.sv
module dbgPortData
  import dbgPortPkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter logic [15:0] FORCE_OP = 16'h1C00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serDataIn,
  input  portStrobe_t       strobe,
  input  logic              respStatus,
  input  logic [DATA_W-1:0] respWord,
  output logic              serDataOut,
  output logic              cmdValid,
  output logic              cmdStatus,
  output logic [DATA_W-1:0] cmdWord,
  output logic              forceAck
);
  localparam int FRAME_W = DATA_W + 1;

  logic dataMeta, dataSync;
  logic [FRAME_W-1:0] rxShift, txShift, rxNext;
  logic isForce;

  assign rxNext  = {rxShift[FRAME_W-2:0], dataSync};
  assign isForce = (rxNext[DATA_W-1:0] == DATA_W'(FORCE_OP));

  always_ff @(posedge clk) begin
    if (rst) begin
      dataMeta <= 1'b0;
      dataSync <= 1'b0;
      rxShift  <= '0;
      txShift  <= '0;
      cmdValid <= 1'b0;
      forceAck <= 1'b0;
    end else begin
      dataMeta <= serDataIn;
      dataSync <= dataMeta;
      cmdValid <= 1'b0;
      forceAck <= 1'b0;
      if (strobe.shiftEn) begin
        rxShift <= rxNext;
        if (strobe.frameEnd) txShift <= {respStatus, respWord};
        else                 txShift <= {txShift[FRAME_W-2:0], 1'b0};
      end
      if (strobe.frameEnd) begin
        cmdValid <= !isForce;
        forceAck <= isForce;
      end
    end
  end

  assign serDataOut = txShift[FRAME_W-1];
  assign cmdStatus  = rxShift[FRAME_W-1];
  assign cmdWord    = rxShift[DATA_W-1:0];
endmodule

// File: rtl/dbgSerialPort.sv
module dbgSerialPort
  import dbgPortPkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter logic [15:0] FORCE_OP = 16'h1C00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              serClkIn,
  input  logic              serDataIn,
  input  logic              respStatus,
  input  logic [DATA_W-1:0] respWord,
  output logic              serDataOut,
  output logic              cmdValid,
  output logic              cmdStatus,
  output logic [DATA_W-1:0] cmdWord,
  output logic              forceAck
);
  portStrobe_t strobe;

  dbgPortCtrl #(.FRAME_BITS(DATA_W + 1)) u_ctrl (
    .clk(clk), .rst(rst), .serClkIn(serClkIn), .strobe(strobe)
  );

  dbgPortData #(.DATA_W(DATA_W), .FORCE_OP(FORCE_OP)) u_data (
    .clk(clk), .rst(rst), .serDataIn(serDataIn), .strobe(strobe),
    .respStatus(respStatus), .respWord(respWord),
    .serDataOut(serDataOut), .cmdValid(cmdValid), .cmdStatus(cmdStatus),
    .cmdWord(cmdWord), .forceAck(forceAck)
  );
endmodule

// File: rtl/dbgSerialPort_chk.sv
module dbgSerialPort_chk (
  input logic clk,
  input logic rst,
  input logic shiftEn,
  input logic serDataOut,
  input logic cmdValid,
  input logic forceAck
);
  // R5: acknowledge lasts one cycle
  p_ack_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    forceAck |=> !forceAck);
  // R2: command strobe lasts one cycle
  p_cmd_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    cmdValid |=> !cmdValid);
  // R7: never both at once
  p_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(cmdValid && forceAck));
  // R3: response line moves only after an accepted edge
  p_dso_on_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(serDataOut) |-> $past(shiftEn));
  // R2: outputs strobe only after an accepted edge
  p_strobe_after_edge_r2: assert property (@(posedge clk) disable iff (rst)
    (cmdValid || forceAck) |-> $past(shiftEn));
  // R8: reset clears the outputs
  p_reset_clears_r8: assert property (@(posedge clk)
    rst |=> (!cmdValid && !forceAck && !serDataOut));
endmodule

bind dbgSerialPort dbgSerialPort_chk u_chk (
  .clk(clk), .rst(rst), .shiftEn(strobe.shiftEn),
  .serDataOut(serDataOut), .cmdValid(cmdValid), .forceAck(forceAck)
);

// File: tb/dbgSerialPort_bench.sv
module dbgSerialPort_bench;
  localparam int HALF = 4;
  localparam int NVEC = 6;
  // {status, command word, response status, response word}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 16'hA5C3, 1'b1, 16'h1234},
    {1'b1, 16'h0001, 1'b0, 16'hFFFF},
    {1'b0, 16'h1C00, 1'b1, 16'h8001},
    {1'b1, 16'h1C01, 1'b0, 16'h5A5A},
    {1'b1, 16'h1C00, 1'b0, 16'h0000},
    {1'b0, 16'hFFFF, 1'b1, 16'hC3A5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serClkIn = 1'b0, serDataIn = 1'b0, respStatus = 1'b0;
  logic [15:0] respWord = '0;
  logic serDataOut, cmdValid, cmdStatus, forceAck;
  logic [15:0] cmdWord;

  int nChecks = 0, nFails = 0;
  int nCmd = 0, nForce = 0, nBoth = 0;
  logic lastSt;
  logic [15:0] lastWord;

  always #10 clk = ~clk;

  dbgSerialPort u_dbgSerialPort (
    .clk(clk), .rst(rst), .serClkIn(serClkIn), .serDataIn(serDataIn),
    .respStatus(respStatus), .respWord(respWord), .serDataOut(serDataOut),
    .cmdValid(cmdValid), .cmdStatus(cmdStatus), .cmdWord(cmdWord),
    .forceAck(forceAck)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (cmdValid) begin nCmd++; lastSt = cmdStatus; lastWord = cmdWord; end
      if (forceAck) nForce++;
      if (cmdValid && forceAck) nBoth++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // send a frame; glitchAt >= 0 inserts a one-cycle clock pulse before that bit
  task automatic sendFrame(input logic [16:0] frm, input int glitchAt,
                           input int stopAfter, output logic [16:0] dso);
    dso = '0;
    for (int i = 16; i >= 0; i--) begin
      if ((16 - i) == stopAfter) return;
      @(negedge clk);
      serClkIn = 1'b0;
      serDataIn = frm[i];
      if ((16 - i) == glitchAt) begin
        repeat (2) @(negedge clk);
        serClkIn = 1'b1;
        @(negedge clk);
        serClkIn = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      dso[i] = serDataOut;
      serClkIn = 1'b1;
      repeat (HALF) @(negedge clk);
    end
    serClkIn = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [16:0] dso;
    logic [16:0] prevResp;
    int c0, f0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check("R8 reset outputs", {29'd0, serDataOut, cmdValid, forceAck}, 32'd0);

    prevResp = '0;  // R4: first frame after reset sends zeros
    for (int v = 0; v < NVEC; v++) begin
      respStatus = VEC[v][16];
      respWord   = VEC[v][15:0];
      c0 = nCmd; f0 = nForce;
      sendFrame(VEC[v][33:17], -1, -1, dso);
      check("R3 R4 response bits", {15'd0, dso}, {15'd0, prevResp});
      if (VEC[v][32:17] == 16'h1C00) begin
        check("R5 force ack one cycle", nForce - f0, 1);
        check("R5 no command strobe", nCmd - c0, 0);
      end else begin
        check("R2 R6 one command strobe", nCmd - c0, 1);
        check("R2 R6 received frame", {15'd0, lastSt, lastWord}, {15'd0, VEC[v][33:17]});
        check("R6 no force ack", nForce - f0, 0);
      end
      prevResp = VEC[v][16:0];
    end

    // R1: single-cycle glitch mid-frame is ignored
    respStatus = 1'b0; respWord = 16'h0F0F;
    c0 = nCmd;
    sendFrame({1'b1, 16'h6B2D}, 8, -1, dso);
    check("R1 glitch frame count", nCmd - c0, 1);
    check("R1 glitch frame word", {15'd0, lastSt, lastWord}, {15'd0, 1'b1, 16'h6B2D});
    check("R1 R3 response intact", {15'd0, dso}, {15'd0, prevResp});

    // R8: reset mid-frame discards partial frame and clears response
    c0 = nCmd;
    sendFrame({1'b1, 16'hFFFF}, -1, 8, dso);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    check("R8 output after reset", {31'd0, serDataOut}, 32'd0);
    sendFrame({1'b0, 16'h3C3C}, -1, -1, dso);
    check("R8 partial frame dropped", nCmd - c0, 1);
    check("R8 fresh frame word", {15'd0, lastSt, lastWord}, {15'd0, 1'b0, 16'h3C3C});
    check("R8 R4 response zeroed", {15'd0, dso}, 32'd0);

    // R7: strobes never coincided
    check("R7 exclusive strobes", nBoth, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule